// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block takes a stereo audio stream arriving on one serial data line, framed by an external bit clock and an LR (channel select) clock. It recovers one left and one right sample per frame and presents them as parallel 24-bit words. A single-cycle strobe marks each new stereo pair. All three serial pins are asynchronous to the block. Each passes through a synchroniser into a faster system clock, and the block finds bit clock rising edges and LR transitions in that domain.

Static configuration inputs select four things. The first is the number of bit clocks per frame (32, 48 or 64). The second is which LR level means the left channel. The third is the framing style: I2S, MSB-justified or LSB-justified. The fourth is the word length (16, 18, 20 or 24 bits). The configuration is expected to change only while the block is held in reset.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, `leftOut` and `rightOut` read zero and `sampleValid` is low until the first stereo pair completes.
- R2: `cfgBclkRate` sets the bit clocks per channel (S): 00 gives 16 (32 per frame), 01 gives 24 (48 per frame), and both 10 and 11 give 32 (64 per frame).
- R3: Bits are sampled on bit clock rising edges, MSB first. Slot k counts rising edges from 0, where slot 0 is the first rising edge that sees the new LR level. `cfgFormat` selects where the MSB sits. With 01 (MSB-justified) the MSB is in slot 0. With 10 or 11 (I2S) the MSB is in slot 1, and a word's last bit may fall in slot 0 of the following channel. With 00 (LSB-justified) the MSB is in slot S minus the effective length, so the LSB is in slot S-1.
- R4: `cfgWordLen` 00/01/10/11 selects 16/18/20/24 bits. The captured bits are left-aligned in the 24-bit output, and every bit below the effective length reads zero.
- R5: `cfgLrPol` = 0 makes LR low the left channel, so a frame starts on an LR falling edge. `cfgLrPol` = 1 makes LR high the left channel, so a frame starts on a rising edge.
- R6: The effective length is the smaller of the word length and S. When the word is longer than S, only the top S bits are captured, and they occupy the channel's slots as in R3.
- R7: Slots outside the captured word have no effect on the outputs, whatever level the data line holds in them.
- R8: `sampleValid` is high for exactly one system clock after a right-channel word completes. `leftOut` and `rightOut` take their new values in that same cycle.
- R9: Nothing is captured until the first LR transition after reset. A right word that has no completed left word since the last pair produces no strobe.
- R10: While `sampleValid` is low, `leftOut` and `rightOut` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Serial bit clock, asynchronous |
| lrclkIn | input | 1 | LR channel clock, asynchronous |
| sdataIn | input | 1 | Serial audio data, asynchronous |
| cfgBclkRate | input | 2 | Bit clocks per frame code |
| cfgLrPol | input | 1 | Level of LR that marks the left channel |
| cfgFormat | input | 2 | Framing style code |
| cfgWordLen | input | 2 | Word length code |
| leftOut | output | 24 | Left sample, left-aligned |
| rightOut | output | 24 | Right sample, left-aligned |
| sampleValid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The hardest case to reach is the I2S word whose effective length equals the slot count. Its LSB lands in slot 0 of the next channel, after the LR level has already flipped, so the word has to keep its original channel tag across the transition. The stimulus reaches it with 16-bit I2S in 32-bit frames and 24-bit I2S in 48-bit frames. A trailing channel follows each burst so that the final spilled bit is actually clocked in. Filler ones go into every unused slot, so any stray capture shows up as a nonzero low bit. A burst that opens on the right channel checks that an unpaired right word raises no strobe.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int POS_W    = $clog2(SAMPLE_W);

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic             clearWord;
    logic             captureEn;
    logic [POS_W-1:0] bitPos;
    logic             dataBit;
    logic             wordDone;
    logic             wordLeft;
  } rxStrobe_t;

  function automatic logic [5:0] slotsPerChan(input logic [1:0] rateCode);
    case (rateCode)
      2'b00:   return 6'd16;
      2'b01:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] wordBits(input logic [1:0] lenCode);
    case (lenCode)
      2'b00:   return POS_W'(16);
      2'b01:   return POS_W'(18);
      2'b10:   return POS_W'(20);
      default: return POS_W'(24);
    endcase
  endfunction

endpackage

// File: rtl/serial_audio_rx_ctrl.sv
module serial_audio_rx_ctrl
  import serial_audio_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bclkIn,
  input  logic             lrclkIn,
  input  logic             sdataIn,
  input  logic [1:0]       cfgBclkRate,
  input  logic             cfgLrPol,
  input  logic [1:0]       cfgFormat,
  input  logic [1:0]       cfgWordLen,
  output logic [POS_W-1:0] effLen,
  output rxStrobe_t        strb
);

  localparam int NUM_PINS = 3;
  localparam int SLOT_W   = 6;

  logic [NUM_PINS-1:0] pinRaw, pinSync;
  assign pinRaw = {sdataIn, lrclkIn, bclkIn};

  for (genvar g = 0; g < NUM_PINS; g++) begin : gSync
    logic [SYNC_STAGES-1:0] stages;
    always_ff @(posedge clk) begin
      if (!rstN) stages <= '0;
      else       stages <= {stages[SYNC_STAGES-2:0], pinRaw[g]};
    end
    assign pinSync[g] = stages[SYNC_STAGES-1];
  end

  logic bclkS, lrS, sdS, bclkD;
  assign bclkS = pinSync[0];
  assign lrS   = pinSync[1];
  assign sdS   = pinSync[2];

  logic              havePrev, prevLr, locked, busy, wordLeftQ;
  logic [SLOT_W-1:0] slotCnt, slotNow, slots, startSlot;
  logic [POS_W-1:0]  wordLen, bitIdx;
  logic              bclkRise, lrChange, curLeft, startNow, contNow, lastBit;

  assign slots   = slotsPerChan(cfgBclkRate);
  assign wordLen = wordBits(cfgWordLen);
  assign effLen  = (SLOT_W'(wordLen) < slots) ? wordLen : slots[POS_W-1:0];

  always_comb begin
    case (cfgFormat)
      2'b00:   startSlot = slots - SLOT_W'(effLen);
      2'b01:   startSlot = '0;
      default: startSlot = SLOT_W'(1);
    endcase
  end

  assign bclkRise = bclkS & ~bclkD;
  assign lrChange = havePrev && (lrS != prevLr);
  assign slotNow  = lrChange ? '0 : ((slotCnt == '1) ? slotCnt : slotCnt + 1'b1);
  assign curLeft  = (lrS == cfgLrPol);
  assign startNow = bclkRise && (locked || lrChange) && (slotNow == startSlot);
  assign contNow  = bclkRise && busy && !startNow;
  assign lastBit  = (bitIdx == effLen - 1'b1);

  always_comb begin
    strb.clearWord = startNow;
    strb.captureEn = startNow | contNow;
    strb.bitPos    = startNow ? '0 : bitIdx;
    strb.dataBit   = sdS;
    strb.wordDone  = contNow & lastBit;
    strb.wordLeft  = wordLeftQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkD     <= 1'b0;
      havePrev  <= 1'b0;
      prevLr    <= 1'b0;
      locked    <= 1'b0;
      slotCnt   <= '0;
      busy      <= 1'b0;
      bitIdx    <= '0;
      wordLeftQ <= 1'b0;
    end else begin
      bclkD <= bclkS;
      if (bclkRise) begin
        havePrev <= 1'b1;
        prevLr   <= lrS;
        slotCnt  <= slotNow;
        if (lrChange) locked <= 1'b1;
        if (startNow) begin
          busy      <= 1'b1;
          bitIdx    <= POS_W'(1);
          wordLeftQ <= curLeft;
        end else if (contNow) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  // R3
  capture_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureEn |=> !strb.captureEn);

  // R6
  bit_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureEn |-> (strb.bitPos < effLen));

endmodule

// File: rtl/serial_audio_rx_dp.sv
module serial_audio_rx_dp
  import serial_audio_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strb,
  input  logic [POS_W-1:0]    effLen,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);

  localparam logic [SAMPLE_W-1:0] TOP_ONE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] wordQ, wordNext, posMask, leftHold;
  logic                leftSeen;

  assign posMask = TOP_ONE >> strb.bitPos;

  always_comb begin
    wordNext = strb.clearWord ? '0 : wordQ;
    if (strb.captureEn)
      wordNext = (wordNext & ~posMask) | (strb.dataBit ? posMask : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ       <= '0;
      leftHold    <= '0;
      leftSeen    <= 1'b0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (strb.captureEn) wordQ <= wordNext;
      if (strb.wordDone) begin
        if (strb.wordLeft) begin
          leftHold <= wordNext;
          leftSeen <= 1'b1;
        end else if (leftSeen) begin
          leftOut     <= leftHold;
          rightOut    <= wordNext;
          sampleValid <= 1'b1;
          leftSeen    <= 1'b0;
        end
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R10
  output_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftOut) && $stable(rightOut)));

  // R4
  zero_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (((leftOut | rightOut) & ({SAMPLE_W{1'b1}} >> effLen)) == '0));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bclkIn,
  input  logic                lrclkIn,
  input  logic                sdataIn,
  input  logic [1:0]          cfgBclkRate,
  input  logic                cfgLrPol,
  input  logic [1:0]          cfgFormat,
  input  logic [1:0]          cfgWordLen,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);

  rxStrobe_t        strb;
  logic [POS_W-1:0] effLen;

  serial_audio_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .cfgBclkRate(cfgBclkRate), .cfgLrPol(cfgLrPol),
    .cfgFormat(cfgFormat), .cfgWordLen(cfgWordLen),
    .effLen(effLen), .strb(strb)
  );

  serial_audio_rx_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .effLen(effLen),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

endmodule

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;

  localparam int HB    = 4;       // system clocks per half bit clock
  localparam int NVEC  = 12;
  localparam int WATCH = 150000;

  // {rate, format, wordLen, pol, left, right}
  localparam logic [54:0] VEC [NVEC] = '{
    {2'b00, 2'b01, 2'b00, 1'b0, 24'hA5C3F0, 24'h3C5A96},
    {2'b00, 2'b10, 2'b00, 1'b1, 24'h81F00F, 24'hF0E1D2},
    {2'b00, 2'b00, 2'b00, 1'b0, 24'h123456, 24'hFEDCBA},
    {2'b00, 2'b01, 2'b11, 1'b0, 24'hC0FFEE, 24'h0BADF0},
    {2'b00, 2'b00, 2'b10, 1'b1, 24'h9ABCDE, 24'h13579B},
    {2'b01, 2'b00, 2'b01, 1'b0, 24'hFFFFFF, 24'h800001},
    {2'b01, 2'b11, 2'b11, 1'b1, 24'hA1B2C3, 24'h5D6E7F},
    {2'b01, 2'b01, 2'b10, 1'b0, 24'h7777F1, 24'h8888EF},
    {2'b10, 2'b00, 2'b11, 1'b1, 24'h2468AC, 24'hECA864},
    {2'b11, 2'b10, 2'b01, 1'b0, 24'hDEADBE, 24'h55AA55},
    {2'b10, 2'b01, 2'b00, 1'b1, 24'h00FF00, 24'hFF00FF},
    {2'b11, 2'b00, 2'b10, 1'b0, 24'h3CC3A5, 24'hC33C5A}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclkIn = 1'b0, lrclkIn = 1'b0, sdataIn = 1'b0;
  logic [1:0]  cfgBclkRate = 2'b00, cfgFormat = 2'b00, cfgWordLen = 2'b00;
  logic        cfgLrPol = 1'b0;
  logic [23:0] leftOut, rightOut;
  logic        sampleValid;

  int checks = 0, fails = 0, cyc = 0;
  int gotCnt = 0, widthErr = 0;
  logic [23:0] gotL [64];
  logic [23:0] gotR [64];
  logic [23:0] words [8];
  logic        prevValid = 1'b0;

  always #2 clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .cfgBclkRate(cfgBclkRate), .cfgLrPol(cfgLrPol), .cfgFormat(cfgFormat),
    .cfgWordLen(cfgWordLen), .leftOut(leftOut), .rightOut(rightOut),
    .sampleValid(sampleValid)
  );

  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      gotL[gotCnt % 64] = leftOut;
      gotR[gotCnt % 64] = rightOut;
      gotCnt++;
    end
    if (rstN && sampleValid && prevValid) widthErr++;
    prevValid = sampleValid;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCH) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WATCH);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int slotsOf(input logic [1:0] r);
    return (r == 2'b00) ? 16 : (r == 2'b01) ? 24 : 32;
  endfunction

  function automatic int effOf(input logic [1:0] r, input logic [1:0] w);
    int wl;
    wl = (w == 2'b00) ? 16 : (w == 2'b01) ? 18 : (w == 2'b10) ? 20 : 24;
    return (wl < slotsOf(r)) ? wl : slotsOf(r);
  endfunction

  function automatic logic [23:0] maskOf(input int weff);
    return ~(24'hFFFFFF >> weff);
  endfunction

  function automatic logic txBit(input int c, input int k, input int s, input int weff,
                                 input logic [1:0] fmt, input int nW);
    if (fmt[1]) begin
      if (k == 0 && c >= 2 && c <= nW + 1 && (s - 1) < weff) return words[c-2][23-(s-1)];
      if (k >= 1 && c >= 1 && c <= nW && (k - 1) < weff)    return words[c-1][23-(k-1)];
    end else if (fmt == 2'b01) begin
      if (c >= 1 && c <= nW && k < weff) return words[c-1][23-k];
    end else begin
      if (c >= 1 && c <= nW && k >= s - weff) return words[c-1][23-(k-(s-weff))];
    end
    return 1'b1;   // filler ones in unused slots
  endfunction

  task automatic slotOut(input logic lr, input logic b);
    @(negedge clk);
    bclkIn = 1'b0; lrclkIn = lr; sdataIn = b;
    repeat (HB) @(negedge clk);
    bclkIn = 1'b1;
    repeat (HB - 1) @(negedge clk);
  endtask

  task automatic doReset(input logic [54:0] v);
    rstN = 1'b0;
    {cfgBclkRate, cfgFormat, cfgWordLen, cfgLrPol} = v[54:48];
    bclkIn = 1'b0; lrclkIn = ~v[48]; sdataIn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
  endtask

  // channel 0 is a filler preamble, channels 1..nW carry words, one trailing filler channel
  task automatic runBurst(input int nW, input int phase);
    int s, weff;
    s = slotsOf(cfgBclkRate);
    weff = effOf(cfgBclkRate, cfgWordLen);
    for (int c = 0; c <= nW + 1; c++) begin
      for (int k = 0; k < s; k++) begin
        slotOut((((c + phase) % 2) == 1) ? cfgLrPol : ~cfgLrPol,
                txBit(c, k, s, weff, cfgFormat, nW));
      end
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int base;
    logic [23:0] m;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(leftOut == 24'h0 && rightOut == 24'h0, "R1 outputs in reset", leftOut | rightOut, 24'h0);
    check(sampleValid == 1'b0, "R1 valid in reset", 24'(sampleValid), 24'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(leftOut == 24'h0 && sampleValid == 1'b0, "R1 after release", leftOut, 24'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      doReset(VEC[i]);
      words[0] = VEC[i][47:24];
      words[1] = VEC[i][23:0];
      words[2] = VEC[i][47:24] ^ 24'h5A5A5A;
      words[3] = VEC[i][23:0] ^ 24'hFFFFFF;
      m = maskOf(effOf(VEC[i][54:53], VEC[i][50:49]));
      base = gotCnt;
      runBurst(4, 0);
      check(gotCnt - base == 2, $sformatf("R8 pair count vec %0d", i), 24'(gotCnt - base), 24'd2);
      for (int p = 0; p < 2; p++) begin
        check(gotL[(base + p) % 64] == (words[2*p] & m),
              $sformatf("R3 R4 R5 R6 R7 left vec %0d pair %0d", i, p),
              gotL[(base + p) % 64], words[2*p] & m);
        check(gotR[(base + p) % 64] == (words[2*p+1] & m),
              $sformatf("R2 R3 R4 R6 R7 right vec %0d pair %0d", i, p),
              gotR[(base + p) % 64], words[2*p+1] & m);
      end
      check(leftOut == (words[2] & m) && rightOut == (words[3] & m),
            $sformatf("R10 hold vec %0d", i), leftOut, words[2] & m);
    end

    // R9: burst opening on a right channel gives no strobe for the lone right word
    doReset(VEC[0]);
    words[0] = 24'hBEEF00; words[1] = 24'h1234AB; words[2] = 24'hCAFE77;
    base = gotCnt;
    runBurst(3, 1);
    check(gotCnt - base == 1, "R9 lone right word", 24'(gotCnt - base), 24'd1);
    check(gotL[base % 64] == 24'h123400, "R9 left pairing", gotL[base % 64], 24'h123400);
    check(gotR[base % 64] == 24'hCAFE00, "R9 right pairing", gotR[base % 64], 24'hCAFE00);

    // R9: no LR transition, nothing captured
    doReset(VEC[1]);
    base = gotCnt;
    for (int k = 0; k < 80; k++) slotOut(1'b0, k[0]);
    repeat (20) @(negedge clk);
    check(gotCnt == base, "R9 no lock no strobe", 24'(gotCnt - base), 24'd0);
    check(leftOut == 24'h0 && rightOut == 24'h0, "R9 no lock outputs", leftOut | rightOut, 24'h0);

    // R8: strobe width
    check(widthErr == 0, "R8 strobe width", 24'(widthErr), 24'd0);

    summary();
    $finish;
  end

endmodule